// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block stores sixty-four 32-bit floating-point registers as raw bit patterns and presents them through several access views, chosen per access by a 3-bit view code. A 32-bit mode word holds three control bits: a bank select, a transfer-size mode and a precision mode. These bits decide which half of the file a banked access reaches, and whether a general or move access is one register wide or a pair. No format conversion takes place. When a view resolves to a single register, the value travels in the low 32 bits of the 64-bit data bus.

Each cycle the block takes one read and one write, each with its own view code and index. The read path is combinational. A write lands at the next rising edge, and a pair write updates both physical registers at that same edge. The mode word is updated either one bit at a time or as a whole word, and it gives way to any register write requested in the same cycle.

Top module: `fpbank_top`

## Requirements
- R1: After reset all 64 registers read as zero and the mode word is 0.
- R2: View code 0 (current single) at index i (0..15) reaches physical register 16*b+i, where b is mode bit 21. A single read returns the register in bits 31:0 with bits 63:32 zero, and a single write stores wrData[31:0].
- R3: View code 1 (opposite single) at index i (0..15) reaches physical register 16*(1-b)+i.
- R4: View code 2 (raw pair) at index i (0..62) joins physical register i as bits 63:32 with register i+1 as bits 31:0. A write splits the value the same way.
- R5: View codes 3 (current pair) and 4 (opposite pair) at index i (0..14) act as a raw pair at 16*b+i and 16*(1-b)+i respectively.
- R6: View code 5 (general) acts as the current pair when mode bit 19 is 1, and as the current single when bit 19 is 0.
- R7: View code 6 (move) at index i (0..15) acts as the current single when mode bit 20 is 0. When bit 20 is 1, an odd i reaches the opposite-bank pair at i with bit 0 cleared, and an even i reaches the raw pair at i.
- R8: A mode write with modeSel 0, 1 or 2 sets bit 21, 20 or 19 to modeData[0] and leaves every other bit unchanged. modeSel 3 loads the whole of modeData.
- R9: Only one write is taken per cycle. If wrEn and modeWrEn are both high, the register write happens and the mode word keeps its value. A pair write updates both registers at the same edge.
- R10: The following index or code values are errors: index above 15 on views 0, 1 and 6; index 63 on view 2; index above 14 on views 3 and 4, and on view 5 when it acts as a pair; view code 7. A write with such a value raises wrErr and stores nothing. A read with such a value raises rdErr and returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Mode word write request |
| modeSel | input | 2 | 0 bank bit, 1 size bit, 2 precision bit, 3 whole word |
| modeData | input | 32 | Bit value in bit 0, or full word for modeSel 3 |
| modeWord | output | 32 | Current mode word |
| wrEn | input | 1 | Register write request |
| wrView | input | 3 | Write view code |
| wrIdx | input | 6 | Write index |
| wrData | input | 64 | Write data |
| wrErr | output | 1 | Requested write is out of range, so it is dropped |
| rdView | input | 3 | Read view code |
| rdIdx | input | 6 | Read index |
| rdData | output | 64 | Read data (combinational) |
| rdErr | output | 1 | Read access is out of range |

## Verification
A wrong bank or pairing decode puts a value into a physical register other than the intended one. That error stays hidden until a different view reads the same location back. For this reason most vectors write through one view and read through another, so a decode error appears at rdData in the cycle after the write. A corrupted mode bit changes the mapping of every later access. The mode word is visible at the port, so bit-write damage shows one cycle after the write. A stray write from an error access becomes visible only when that location is read later, and later vectors read those locations on purpose.

// File: rtl/fpbank_pkg.sv
package fpbank_pkg;

  localparam int FR_COUNT  = 64;
  localparam int FR_W      = 32;
  localparam int BANK_SPAN = 16;
  localparam int FR_AW     = $clog2(FR_COUNT);
  localparam int PAIR_W    = 2 * FR_W;

  typedef enum logic [2:0] {
    VW_SCUR = 3'd0,
    VW_SOPP = 3'd1,
    VW_DRAW = 3'd2,
    VW_DCUR = 3'd3,
    VW_DOPP = 3'd4,
    VW_GEN  = 3'd5,
    VW_MOVE = 3'd6,
    VW_NONE = 3'd7
  } view_e;

  // One decoded access: valid flag, width and first physical register.
  typedef struct packed {
    logic             ok;
    logic             pair;
    logic [FR_AW-1:0] addr;
  } acc_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             wrEn;
    logic             wrPair;
    logic [FR_AW-1:0] wrAddr;
    logic             rdOk;
    logic             rdPair;
    logic [FR_AW-1:0] rdAddr;
  } strobe_t;

endpackage

// File: rtl/fpbank_ctrl.sv
module fpbank_ctrl
  import fpbank_pkg::*;
#(
  parameter int MODE_W   = 32,
  parameter int BANK_BIT = 21,
  parameter int SIZE_BIT = 20,
  parameter int PREC_BIT = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic [1:0]        modeSel,
  input  logic [MODE_W-1:0] modeData,
  output logic [MODE_W-1:0] modeWord,
  input  logic              wrReq,
  input  logic [2:0]        wrView,
  input  logic [FR_AW-1:0]  wrIdx,
  input  logic [2:0]        rdView,
  input  logic [FR_AW-1:0]  rdIdx,
  output logic              wrErr,
  output logic              rdErr,
  output strobe_t           stb
);

  localparam logic [FR_AW-1:0] SPAN    = FR_AW'(BANK_SPAN);
  localparam logic [FR_AW-1:0] LASTRAW = FR_AW'(FR_COUNT - 1);
  localparam logic [MODE_W-1:0] CTRL_MASK =
    (MODE_W'(1) << BANK_BIT) | (MODE_W'(1) << SIZE_BIT) | (MODE_W'(1) << PREC_BIT);

  logic bankSel, sizeMode, precMode;
  assign bankSel  = modeWord[BANK_BIT];
  assign sizeMode = modeWord[SIZE_BIT];
  assign precMode = modeWord[PREC_BIT];

  function automatic acc_t bankedAcc(input logic [FR_AW-1:0] base,
                                     input logic [FR_AW-1:0] idx,
                                     input logic wantPair);
    acc_t a;
    a.pair = wantPair;
    a.ok   = wantPair ? (idx < SPAN - 1'b1) : (idx < SPAN);
    a.addr = base + idx;
    return a;
  endfunction

  function automatic acc_t decodeAcc(input logic [2:0] code,
                                     input logic [FR_AW-1:0] idx,
                                     input logic bnk, input logic sz,
                                     input logic pr);
    acc_t a;
    logic [FR_AW-1:0] curBase, oppBase;
    curBase = bnk ? SPAN : '0;
    oppBase = bnk ? '0 : SPAN;
    a = '0;
    case (view_e'(code))
      VW_SCUR: a = bankedAcc(curBase, idx, 1'b0);
      VW_SOPP: a = bankedAcc(oppBase, idx, 1'b0);
      VW_DRAW: begin
        a.ok   = idx < LASTRAW;
        a.pair = 1'b1;
        a.addr = idx;
      end
      VW_DCUR: a = bankedAcc(curBase, idx, 1'b1);
      VW_DOPP: a = bankedAcc(oppBase, idx, 1'b1);
      VW_GEN:  a = bankedAcc(curBase, idx, pr);
      VW_MOVE: begin
        if (!sz) begin
          a = bankedAcc(curBase, idx, 1'b0);
        end else begin
          a.ok   = idx < SPAN;
          a.pair = 1'b1;
          a.addr = idx[0] ? (oppBase + {idx[FR_AW-1:1], 1'b0}) : idx;
        end
      end
      default: a = '0;
    endcase
    if (!a.ok) begin
      a.pair = 1'b0;
      a.addr = '0;
    end
    return a;
  endfunction

  acc_t wrAcc, rdAcc;
  always_comb begin
    wrAcc = decodeAcc(wrView, wrIdx, bankSel, sizeMode, precMode);
    rdAcc = decodeAcc(rdView, rdIdx, bankSel, sizeMode, precMode);
  end

  always_comb begin
    stb.wrEn   = wrReq && wrAcc.ok;
    stb.wrPair = wrAcc.pair;
    stb.wrAddr = wrAcc.addr;
    stb.rdOk   = rdAcc.ok;
    stb.rdPair = rdAcc.pair;
    stb.rdAddr = rdAcc.addr;
  end

  assign wrErr = wrReq && !wrAcc.ok;
  assign rdErr = !rdAcc.ok;

  // Mode word: a register write request in the same cycle blocks the update.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeWord <= '0;
    end else if (modeWrEn && !wrReq) begin
      case (modeSel)
        2'd0:    modeWord[BANK_BIT] <= modeData[0];
        2'd1:    modeWord[SIZE_BIT] <= modeData[0];
        2'd2:    modeWord[PREC_BIT] <= modeData[0];
        default: modeWord <= modeData;
      endcase
    end
  end

  // R8: a single-bit update leaves every non-control bit as it was
  a_r8_keep_other_bits: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && !wrReq && modeSel != 2'd3)
      |=> (((modeWord ^ $past(modeWord)) & ~CTRL_MASK) == '0));

  // R9: a register write in the same cycle wins over a mode write
  a_r9_mode_blocked: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> $stable(modeWord));

  // R8: the addressed bit takes the requested value
  a_r8_bank_bit_set: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && !wrReq && modeSel == 2'd0) |=> (modeWord[BANK_BIT] == $past(modeData[0])));

endmodule

// File: rtl/fpbank_dp.sv
module fpbank_dp
  import fpbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [PAIR_W-1:0] wrData,
  output logic [PAIR_W-1:0] rdData
);

  logic [FR_COUNT-1:0][FR_W-1:0] regs;
  logic [FR_AW-1:0] wrNext, rdNext;

  assign wrNext = stb.wrAddr + 1'b1;
  assign rdNext = stb.rdAddr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regs <= '0;
    end else if (stb.wrEn) begin
      if (stb.wrPair) begin
        regs[stb.wrAddr] <= wrData[PAIR_W-1:FR_W];
        regs[wrNext]     <= wrData[FR_W-1:0];
      end else begin
        regs[stb.wrAddr] <= wrData[FR_W-1:0];
      end
    end
  end

  always_comb begin
    if (!stb.rdOk)
      rdData = '0;
    else if (stb.rdPair)
      rdData = {regs[stb.rdAddr], regs[rdNext]};
    else
      rdData = {{FR_W{1'b0}}, regs[stb.rdAddr]};
  end

  // R10: without an accepted write strobe the storage holds still
  a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn |=> $stable(regs));

  // R9: a pair write lands in both registers at the same edge
  a_r9_pair_both_halves: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && stb.wrPair)
      |=> (regs[$past(stb.wrAddr)] == $past(wrData[PAIR_W-1:FR_W]))
       && (regs[$past(wrNext)] == $past(wrData[FR_W-1:0])));

endmodule

// File: rtl/fpbank_top.sv
module fpbank_top
  import fpbank_pkg::*;
#(
  parameter int MODE_W   = 32,
  parameter int BANK_BIT = 21,
  parameter int SIZE_BIT = 20,
  parameter int PREC_BIT = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic [1:0]        modeSel,
  input  logic [MODE_W-1:0] modeData,
  output logic [MODE_W-1:0] modeWord,
  input  logic              wrEn,
  input  logic [2:0]        wrView,
  input  logic [5:0]        wrIdx,
  input  logic [63:0]       wrData,
  output logic              wrErr,
  input  logic [2:0]        rdView,
  input  logic [5:0]        rdIdx,
  output logic [63:0]       rdData,
  output logic              rdErr
);

  strobe_t stb;

  fpbank_ctrl #(
    .MODE_W(MODE_W), .BANK_BIT(BANK_BIT), .SIZE_BIT(SIZE_BIT), .PREC_BIT(PREC_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .modeWrEn(modeWrEn), .modeSel(modeSel), .modeData(modeData), .modeWord(modeWord),
    .wrReq(wrEn), .wrView(wrView), .wrIdx(wrIdx),
    .rdView(rdView), .rdIdx(rdIdx),
    .wrErr(wrErr), .rdErr(rdErr), .stb(stb)
  );

  fpbank_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .rdData(rdData)
  );

  // R10: a rejected read drives zero data
  a_r10_err_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> (rdData == '0));

endmodule

// File: tb/sim_fpbank_top.sv
module sim_fpbank_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeWrEn = 1'b0;
  logic [1:0]  modeSel = '0;
  logic [31:0] modeData = '0;
  logic [31:0] modeWord;
  logic        wrEn = 1'b0;
  logic [2:0]  wrView = '0;
  logic [5:0]  wrIdx = '0;
  logic [63:0] wrData = '0;
  logic        wrErr;
  logic [2:0]  rdView = '0;
  logic [5:0]  rdIdx = '0;
  logic [63:0] rdData;
  logic        rdErr;

  int testCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  fpbank_top u0 (
    .clk(clk), .rstN(rstN),
    .modeWrEn(modeWrEn), .modeSel(modeSel), .modeData(modeData), .modeWord(modeWord),
    .wrEn(wrEn), .wrView(wrView), .wrIdx(wrIdx), .wrData(wrData), .wrErr(wrErr),
    .rdView(rdView), .rdIdx(rdIdx), .rdData(rdData), .rdErr(rdErr)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] mode;
    logic [2:0]  wv;
    logic [5:0]  wi;
    logic [63:0] wd;
    logic        expWErr;
    logic [2:0]  rv;
    logic [5:0]  ri;
    logic [63:0] expRd;
    logic        expRErr;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    // R2: current single write keeps low half only
    '{4'd2,  32'h0000_0000, 3'd0, 6'd3,  64'hFFFF_FFFF_A000_0003, 1'b0, 3'd0, 6'd3,  64'h0000_0000_A000_0003, 1'b0},
    // R3: bank 1, write phys 19, opposite read reaches phys 3
    '{4'd3,  32'h0020_0000, 3'd0, 6'd3,  64'h0000_0000_B000_0013, 1'b0, 3'd1, 6'd3,  64'h0000_0000_A000_0003, 1'b0},
    // R3 + R10: bank 0, opposite read reaches phys 19, code 7 write dropped
    '{4'd3,  32'h0000_0000, 3'd7, 6'd0,  64'hDEAD_BEEF_DEAD_BEEF, 1'b1, 3'd1, 6'd3,  64'h0000_0000_B000_0013, 1'b0},
    // R4: raw pair at 40, read pair at 41
    '{4'd4,  32'h0000_0000, 3'd2, 6'd40, 64'h1111_2222_3333_4444, 1'b0, 3'd2, 6'd41, 64'h3333_4444_0000_0000, 1'b0},
    // R5: bank 1 current pair at 4 -> phys 20/21
    '{4'd5,  32'h0020_0000, 3'd3, 6'd4,  64'h5555_6666_7777_8888, 1'b0, 3'd0, 6'd5,  64'h0000_0000_7777_8888, 1'b0},
    // R5 + R10: bank 0 opposite pair 4 -> 20/21; current pair 15 rejected
    '{4'd5,  32'h0000_0000, 3'd3, 6'd15, 64'h9876_5432_1234_5678, 1'b1, 3'd4, 6'd4,  64'h5555_6666_7777_8888, 1'b0},
    // R6: precision set, general view is a pair
    '{4'd6,  32'h0008_0000, 3'd5, 6'd6,  64'h0102_0304_0506_0708, 1'b0, 3'd3, 6'd6,  64'h0102_0304_0506_0708, 1'b0},
    // R6: precision clear, general view is a single
    '{4'd6,  32'h0000_0000, 3'd5, 6'd8,  64'hAAAA_BBBB_CCCC_DDDD, 1'b0, 3'd5, 6'd8,  64'h0000_0000_CCCC_DDDD, 1'b0},
    // R6: phys 9 untouched by the single write
    '{4'd6,  32'h0000_0000, 3'd7, 6'd0,  64'h0,                   1'b1, 3'd2, 6'd8,  64'hCCCC_DDDD_0000_0000, 1'b0},
    // R7: size set, odd index -> opposite-bank pair at 2
    '{4'd7,  32'h0030_0000, 3'd6, 6'd3,  64'h9999_0000_0000_9999, 1'b0, 3'd4, 6'd2,  64'h9999_0000_0000_9999, 1'b0},
    // R7: size set, even index -> raw pair at 10
    '{4'd7,  32'h0010_0000, 3'd6, 6'd10, 64'h0A0A_0A0A_0B0B_0B0B, 1'b0, 3'd2, 6'd10, 64'h0A0A_0A0A_0B0B_0B0B, 1'b0},
    // R7: size clear, current single in bank 1 -> phys 17
    '{4'd7,  32'h0020_0000, 3'd6, 6'd1,  64'h0000_0000_1234_5678, 1'b0, 3'd0, 6'd1,  64'h0000_0000_1234_5678, 1'b0},
    // R10: single index 16
    '{4'd10, 32'h0000_0000, 3'd7, 6'd0,  64'h0,                   1'b1, 3'd0, 6'd16, 64'h0,                   1'b1},
    // R10: raw pair index 63
    '{4'd10, 32'h0000_0000, 3'd7, 6'd0,  64'h0,                   1'b1, 3'd2, 6'd63, 64'h0,                   1'b1},
    // R10: view code 7
    '{4'd10, 32'h0000_0000, 3'd7, 6'd0,  64'h0,                   1'b1, 3'd7, 6'd0,  64'h0,                   1'b1},
    // R10: move index 16 with size set
    '{4'd10, 32'h0010_0000, 3'd7, 6'd0,  64'h0,                   1'b1, 3'd6, 6'd16, 64'h0,                   1'b1},
    // R10: dropped code-7 write left phys 0 alone
    '{4'd10, 32'h0000_0000, 3'd7, 6'd0,  64'h0,                   1'b1, 3'd0, 6'd0,  64'h0,                   1'b0},
    // R10: dropped pair write at 15 left phys 15/16 alone
    '{4'd10, 32'h0000_0000, 3'd7, 6'd0,  64'h0,                   1'b1, 3'd2, 6'd15, 64'h0,                   1'b0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic loadMode(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    modeWrEn = 1'b1; modeSel = sel; modeData = val;
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    #5;
    check("R1 mode word", {32'h0, modeWord}, 64'h0);
    rdView = 3'd2; rdIdx = 6'd30;
    #1 check("R1 raw pair 30", rdData, 64'h0);

    for (int k = 0; k < NVEC; k++) begin
      loadMode(2'd3, VECS[k].mode);
      wrView = VECS[k].wv; wrIdx = VECS[k].wi; wrData = VECS[k].wd; wrEn = 1'b1;
      #5 check($sformatf("R%0d vec %0d wrErr", VECS[k].req, k), {63'h0, wrErr}, {63'h0, VECS[k].expWErr});
      @(negedge clk);
      wrEn = 1'b0;
      rdView = VECS[k].rv; rdIdx = VECS[k].ri;
      #5;
      check($sformatf("R%0d vec %0d rdData", VECS[k].req, k), rdData, VECS[k].expRd);
      check($sformatf("R%0d vec %0d rdErr", VECS[k].req, k), {63'h0, rdErr}, {63'h0, VECS[k].expRErr});
    end

    // R8: single-bit updates preserve the rest of the word
    loadMode(2'd3, 32'hFFFF_FFFF);
    #5 check("R8 full load", {32'h0, modeWord}, 64'h0000_0000_FFFF_FFFF);
    loadMode(2'd0, 32'h0);
    #5 check("R8 clear bank bit", {32'h0, modeWord}, 64'h0000_0000_FFDF_FFFF);
    loadMode(2'd1, 32'hFFFF_FFFE);
    #5 check("R8 clear size bit", {32'h0, modeWord}, 64'h0000_0000_FFCF_FFFF);
    loadMode(2'd2, 32'h0);
    #5 check("R8 clear precision bit", {32'h0, modeWord}, 64'h0000_0000_FFC7_FFFF);
    loadMode(2'd1, 32'h1);
    #5 check("R8 set size bit", {32'h0, modeWord}, 64'h0000_0000_FFD7_FFFF);

    // R9: simultaneous register and mode writes
    @(negedge clk);
    modeWrEn = 1'b1; modeSel = 2'd3; modeData = 32'h0;
    wrEn = 1'b1; wrView = 3'd0; wrIdx = 6'd0; wrData = 64'h0000_0000_CAFE_F00D;
    @(negedge clk);
    modeWrEn = 1'b0; wrEn = 1'b0;
    rdView = 3'd2; rdIdx = 6'd0;
    #5;
    check("R9 mode kept", {32'h0, modeWord}, 64'h0000_0000_FFD7_FFFF);
    check("R9 register written", rdData, 64'hCAFE_F00D_0000_0000);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule